// File: doc/BRIEF.md
# Serial Configuration Register Slave with Nonvolatile Backup

This block is a two-wire (I2C-style) slave that holds three configuration registers for a multiphase clock generator. These are a control byte, a 4-bit frequency code and an address/write-control register. It samples SCL and SDA, which the surrounding logic has already synchronised to `clk`. It answers on the bus only by enabling a pull-down on SDA, and it never holds SCL low. The working registers drive the generator directly through `cfgCtrl` and `cfgFreq`.

A shadow copy inside the block stands in for nonvolatile storage. When a committing transfer ends with STOP, the selected working registers are copied into the shadow. A busy timer then runs for `NV_BUSY_CYCLES` clocks, and during that time the slave ignores its own address. A write-control bit chooses how register writes reach the shadow. Either every write is backed up automatically, or backup waits for an explicit store command. A write to the address register always reaches the shadow. `rstN` acts as a power-on reset: it reloads the working registers from the shadow. `nvInitN` loads the shadow with its factory values and must be released before `rstN`.

Top module: `nvCfgSlave`

## Requirements
- R1: The device byte is `1011` followed by the three address bits held in bits 2:0 of register 0Dh, with R/W in bit 0. After factory initialisation the slave answers B0h for writes and B1h for reads. Any other device byte gets no acknowledge, and the slave stays silent until the next START.
- R2: A write is START, the device byte with R/W=0, a register address, one data byte and STOP. All bytes travel MSB first. The slave pulls SDA low during the ninth clock of each of the three bytes, and the addressed working register takes the data.
- R3: A read is a write of the register address, then a repeated START, the device byte with R/W=1 and one data byte driven by the slave MSB first. The master sends NACK and then STOP. The slave releases SDA after the eighth data bit.
- R4: Register 02h is a full byte. From bit 7 down it holds dither rate [7:6], phase mode [5:4], dither amount [3:2] and prescaler [1:0]. Its factory value is CDh. `cfgCtrl` always shows the working value.
- R5: Register 08h holds the frequency code in bits 3:0 and reads back as {1111, code}. Its factory value is 0. `cfgFreq` shows the working code.
- R6: Register 0Dh holds the write-control bit in bit 3 and the address bits in bits 2:0. It reads back as {1111, wc, addr}, and its factory value is 0.
- R7: Any register address other than 02h, 08h, 0Dh or 3Fh is acknowledged. Data written to such an address changes nothing and starts no busy time, and a read from it returns FFh.
- R8: With write-control 0, each write to 02h or 08h is copied to the shadow at the next STOP, and the busy time starts there.
- R9: With write-control 1, writes to 02h and 08h stay in the working registers only, and their STOP starts no busy time. A write whose register address byte is 3Fh copies all three registers to the shadow at STOP and starts the busy time.
- R10: A write to 0Dh reaches the shadow at the next STOP whatever the write-control bit holds, and the new device address takes effect at once.
- R11: For `NV_BUSY_CYCLES` clocks after a committing STOP the slave acknowledges no device byte. After that it acknowledges again.
- R12: While `nvInitN` is low the shadow takes the factory values. While `rstN` is low the working registers are loaded from the shadow, so uncommitted values are lost.
- R13: The SDA pull-down changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; reloads working registers from the shadow |
| nvInitN | input | 1 | Synchronous active-low load of factory values into the shadow |
| sclIn | input | 1 | Synchronised serial clock |
| sdaIn | input | 1 | Synchronised serial data (bus level) |
| sdaPullDown | output | 1 | Enables the open-drain pull-down on SDA |
| cfgCtrl | output | 8 | Working control byte (register 02h) |
| cfgFreq | output | 4 | Working frequency code (register 08h) |

## Verification
The hardest case to reach from the ports is the busy window. It is invisible except as a missing acknowledge, and only a committing STOP opens it. The bench gives the block a busy time longer than one byte on the bus. It then sends a bare device byte straight after each STOP, so it can tell a committing write from a non-committing one: with write-control 1 and no store command, the probe must still be acknowledged. The contents of the shadow cannot be read directly. The bench exposes them by pulsing `rstN` and then reading back registers whose working value it had changed without committing.

// File: rtl/nvRegPkg.sv
package nvRegPkg;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 4;
  localparam int NUM_REGS   = 3;
  localparam int FREQ_W     = 4;
  localparam int SUB_ADDR_W = 3;
  localparam int WC_BIT     = 3;

  localparam int IDX_CTRL = 0;
  localparam int IDX_FREQ = 1;
  localparam int IDX_ADDR = 2;

  localparam logic [3:0]        DEV_PREFIX = 4'b1011;
  localparam logic [BYTE_W-1:0] STORE_CMD  = 8'h3F;

  // per-register tables, index 0 in the low byte
  localparam logic [NUM_REGS*BYTE_W-1:0] REG_ADDRS    = {8'h0D, 8'h08, 8'h02};
  localparam logic [NUM_REGS*BYTE_W-1:0] REG_MASKS    = {8'h0F, 8'h0F, 8'hFF};
  localparam logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = {8'h00, 8'h00, 8'hCD};
  localparam logic [NUM_REGS-1:0]        ALWAYS_COMMIT = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_PTR, ST_ACK_PTR,
    ST_WDATA, ST_ACK_DATA, ST_RDATA, ST_RACK, ST_IGNORE
  } busStateT;

  typedef struct packed {
    logic shiftIn;
    logic clrBits;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic commit;
  } strobeT;
endpackage

// File: rtl/nvRegDatapath.sv
module nvRegDatapath import nvRegPkg::*; #(
  parameter int NV_BUSY_CYCLES = 500
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               nvInitN,
  input  logic                               sdaIn,
  input  strobeT                             strb,
  output logic                               byteDone,
  output logic                               addrHit,
  output logic                               rxLsb,
  output logic                               rdMsb,
  output logic                               txNext,
  output logic                               busy,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]    shadowFlat,
  output logic [BYTE_W-1:0]                  ctrlOut,
  output logic [FREQ_W-1:0]                  freqOut
);
  localparam int BUSY_W = $clog2(NV_BUSY_CYCLES + 1);

  logic [BYTE_W-1:0]              rxShift;
  logic [BYTE_W-2:0]              txShift;
  logic [BYTE_W-1:0]              regPtr;
  logic [BYTE_W-1:0]              rdByte;
  logic [CNT_W-1:0]               bitCnt;
  logic [NUM_REGS-1:0][BYTE_W-1:0] workReg;
  logic [NUM_REGS-1:0][BYTE_W-1:0] shadowReg;
  logic [NUM_REGS-1:0]            pending;
  logic [NUM_REGS-1:0]            ptrHit;
  logic [BUSY_W-1:0]              busyCnt;
  logic                           wcBit;
  logic                           storeHit;

  assign wcBit    = workReg[IDX_ADDR][WC_BIT];
  assign storeHit = (rxShift == STORE_CMD);
  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign busy     = (busyCnt != '0);
  assign rxLsb    = rxShift[0];
  assign addrHit  = !busy && (rxShift[BYTE_W-1:BYTE_W-4] == DEV_PREFIX)
                    && (rxShift[SUB_ADDR_W:1] == workReg[IDX_ADDR][SUB_ADDR_W-1:0]);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_decode
      assign ptrHit[g] = (regPtr == REG_ADDRS[g*BYTE_W +: BYTE_W]);
    end
  endgenerate

  always_comb begin
    rdByte = '1;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptrHit[i]) rdByte = workReg[i] | ~REG_MASKS[i*BYTE_W +: BYTE_W];
  end
  assign rdMsb  = rdByte[BYTE_W-1];
  assign txNext = txShift[BYTE_W-2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
      if (strb.clrBits)      bitCnt <= '0;
      else if (strb.shiftIn) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regPtr  <= '0;
      txShift <= '1;
    end else begin
      if (strb.loadPtr) regPtr <= rxShift;
      if (strb.loadTx)       txShift <= rdByte[BYTE_W-2:0];
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-3:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) workReg <= shadowReg;
    else if (strb.writeReg)
      for (int i = 0; i < NUM_REGS; i++)
        if (ptrHit[i]) workReg[i] <= rxShift & REG_MASKS[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else if (strb.commit) pending <= '0;
    else begin
      if (strb.loadPtr && storeHit) pending <= '1;
      if (strb.writeReg)
        for (int i = 0; i < NUM_REGS; i++)
          if (ptrHit[i] && (ALWAYS_COMMIT[i] || !wcBit)) pending[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!nvInitN) shadowReg <= REG_DEFAULTS;
    else if (rstN && strb.commit)
      for (int i = 0; i < NUM_REGS; i++)
        if (pending[i]) shadowReg[i] <= workReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (strb.commit && (pending != '0)) busyCnt <= BUSY_W'(NV_BUSY_CYCLES);
    else if (busy) busyCnt <= busyCnt - 1'b1;
  end

  assign shadowFlat = shadowReg;
  assign ctrlOut    = workReg[IDX_CTRL];
  assign freqOut    = workReg[IDX_FREQ][FREQ_W-1:0];
endmodule

// File: rtl/nvRegControl.sv
module nvRegControl import nvRegPkg::*; (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  logic   byteDone,
  input  logic   addrHit,
  input  logic   rxLsb,
  input  logic   rdMsb,
  input  logic   txNext,
  output strobeT strb,
  output logic   sdaPullDown
);
  busStateT state, stateNext;
  logic sclPrev, sdaPrev;
  logic pullDown, pdNext;
  logic readMode, readNext;
  logic sclRise, sclFall, startSeen, stopSeen;

  assign sclRise   = sclIn && !sclPrev;
  assign sclFall   = !sclIn && sclPrev;
  assign startSeen = sclIn && sclPrev && sdaPrev && !sdaIn;
  assign stopSeen  = sclIn && sclPrev && !sdaPrev && sdaIn;

  always_comb begin
    stateNext    = state;
    pdNext       = pullDown;
    readNext     = readMode;
    strb         = '0;
    strb.shiftIn = sclRise;
    if (startSeen) begin
      stateNext    = ST_ADDR;
      pdNext       = 1'b0;
      strb.clrBits = 1'b1;
    end else if (stopSeen) begin
      stateNext   = ST_IDLE;
      pdNext      = 1'b0;
      strb.commit = 1'b1;
    end else if (sclFall) begin
      case (state)
        ST_ADDR: if (byteDone) begin
          strb.clrBits = 1'b1;
          if (addrHit) begin
            stateNext = ST_ACK_ADDR;
            pdNext    = 1'b1;
            readNext  = rxLsb;
          end else begin
            stateNext = ST_IGNORE;
          end
        end
        ST_ACK_ADDR: begin
          strb.clrBits = 1'b1;
          if (readMode) begin
            stateNext   = ST_RDATA;
            strb.loadTx = 1'b1;
            pdNext      = !rdMsb;
          end else begin
            stateNext = ST_PTR;
            pdNext    = 1'b0;
          end
        end
        ST_PTR: if (byteDone) begin
          strb.clrBits = 1'b1;
          strb.loadPtr = 1'b1;
          stateNext    = ST_ACK_PTR;
          pdNext       = 1'b1;
        end
        ST_ACK_PTR, ST_ACK_DATA: begin
          strb.clrBits = 1'b1;
          stateNext    = ST_WDATA;
          pdNext       = 1'b0;
        end
        ST_WDATA: if (byteDone) begin
          strb.clrBits  = 1'b1;
          strb.writeReg = 1'b1;
          stateNext     = ST_ACK_DATA;
          pdNext        = 1'b1;
        end
        ST_RDATA: begin
          if (byteDone) begin
            strb.clrBits = 1'b1;
            stateNext    = ST_RACK;
            pdNext       = 1'b0;
          end else begin
            strb.shiftTx = 1'b1;
            pdNext       = !txNext;
          end
        end
        ST_RACK: begin
          strb.clrBits = 1'b1;
          if (!rxLsb) begin
            stateNext   = ST_RDATA;
            strb.loadTx = 1'b1;
            pdNext      = !rdMsb;
          end else begin
            stateNext = ST_IGNORE;
            pdNext    = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pullDown <= 1'b0;
      readMode <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      state    <= stateNext;
      pullDown <= pdNext;
      readMode <= readNext;
      sclPrev  <= sclIn;
      sdaPrev  <= sdaIn;
    end
  end

  assign sdaPullDown = pullDown;
endmodule

// File: rtl/nvCfgSlave.sv
module nvCfgSlave import nvRegPkg::*; #(
  parameter int NV_BUSY_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvInitN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullDown,
  output logic [BYTE_W-1:0] cfgCtrl,
  output logic [FREQ_W-1:0] cfgFreq
);
  strobeT strb;
  logic byteDone, addrHit, rxLsb, rdMsb, txNext, busyFlag;
  logic commitStrb, writeStrb;
  logic [NUM_REGS-1:0][BYTE_W-1:0] shadowFlat;

  assign commitStrb = strb.commit;
  assign writeStrb  = strb.writeReg;

  nvRegControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .byteDone   (byteDone),
    .addrHit    (addrHit),
    .rxLsb      (rxLsb),
    .rdMsb      (rdMsb),
    .txNext     (txNext),
    .strb       (strb),
    .sdaPullDown(sdaPullDown)
  );

  nvRegDatapath #(.NV_BUSY_CYCLES(NV_BUSY_CYCLES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .nvInitN   (nvInitN),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .byteDone  (byteDone),
    .addrHit   (addrHit),
    .rxLsb     (rxLsb),
    .rdMsb     (rdMsb),
    .txNext    (txNext),
    .busy      (busyFlag),
    .shadowFlat(shadowFlat),
    .ctrlOut   (cfgCtrl),
    .freqOut   (cfgFreq)
  );
endmodule

// File: rtl/nvCfgSlaveChecker.sv
module nvCfgSlaveChecker import nvRegPkg::*; (
  input logic                            clk,
  input logic                            rstN,
  input logic                            nvInitN,
  input logic                            sclIn,
  input logic                            sdaPullDown,
  input logic                            busyFlag,
  input logic                            commitStrb,
  input logic                            writeStrb,
  input logic [NUM_REGS-1:0][BYTE_W-1:0] shadowFlat,
  input logic [FREQ_W-1:0]               cfgFreq
);
  // R13: the slave moves SDA only in the low phase of SCL
  p_pd_scl_low_r13: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullDown != $past(sdaPullDown)) |-> !sclIn);

  // R11: nothing is acknowledged while the backup is in progress
  p_busy_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> !sdaPullDown);

  // R8: the busy window opens only on a STOP
  p_busy_after_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> $past(commitStrb));

  // R9: the shadow changes only at a STOP commit
  p_shadow_at_stop_r9: assert property (@(posedge clk) disable iff (!rstN || !nvInitN)
    (shadowFlat != $past(shadowFlat)) |-> $past(commitStrb));

  // R5: the working frequency code moves only on a data write
  p_freq_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFreq != $past(cfgFreq)) |-> $past(writeStrb));
endmodule

bind nvCfgSlave nvCfgSlaveChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .nvInitN    (nvInitN),
  .sclIn      (sclIn),
  .sdaPullDown(sdaPullDown),
  .busyFlag   (busyFlag),
  .commitStrb (commitStrb),
  .writeStrb  (writeStrb),
  .shadowFlat (shadowFlat),
  .cfgFreq    (cfgFreq)
);

// File: tb/nvCfgSlave_bench.sv
module nvCfgSlave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 4;
  localparam int BUSY_CYC   = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nvInitN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaPullDown;
  logic sdaLine;
  logic [7:0] cfgCtrl;
  logic [3:0] cfgFreq;

  int checkCount = 0;
  int errorCount = 0;
  int pdHighChanges = 0;
  logic pdPrev = 1'b0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = mSda & ~sdaPullDown;

  nvCfgSlave #(.NV_BUSY_CYCLES(BUSY_CYC)) u_nvCfgSlave (
    .clk(clk), .rstN(rstN), .nvInitN(nvInitN),
    .sclIn(mScl), .sdaIn(sdaLine), .sdaPullDown(sdaPullDown),
    .cfgCtrl(cfgCtrl), .cfgFreq(cfgFreq)
  );

  // R13 monitor: count pull-down changes seen with SCL high
  always @(negedge clk) begin
    if (rstN && mScl && (sdaPullDown !== pdPrev)) pdHighChanges <= pdHighChanges + 1;
    pdPrev <= sdaPullDown;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      errorCount++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic startC;
    mSda = 1'b1; tick(QTR); mScl = 1'b1; tick(QTR);
    mSda = 1'b0; tick(QTR); mScl = 1'b0; tick(QTR);
  endtask

  task automatic stopC;
    mSda = 1'b0; tick(QTR); mScl = 1'b1; tick(QTR);
    mSda = 1'b1; tick(QTR);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(QTR); mScl = 1'b1; tick(2*QTR); mScl = 1'b0; tick(QTR);
    end
    mSda = 1'b1; tick(QTR); mScl = 1'b1; tick(QTR);
    ack = !sdaLine;
    tick(QTR); mScl = 1'b0; tick(QTR);
  endtask

  task automatic getByte(input logic masterAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; tick(QTR); mScl = 1'b1; tick(QTR);
      b[i] = sdaLine;
      tick(QTR); mScl = 1'b0; tick(QTR);
    end
    mSda = !masterAck; tick(QTR); mScl = 1'b1; tick(2*QTR); mScl = 1'b0; tick(QTR);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] sub, input logic rd);
    return {4'b1011, sub, rd};
  endfunction

  task automatic writeTx(input logic [2:0] sub, input logic [7:0] ptr,
                         input logic [7:0] data, output logic ok);
    logic a0, a1, a2;
    a1 = 1'b0; a2 = 1'b0;
    startC; sendByte(dev(sub, 1'b0), a0);
    if (a0) begin sendByte(ptr, a1); sendByte(data, a2); end
    stopC;
    ok = a0 & a1 & a2;
  endtask

  task automatic storeTx(input logic [2:0] sub, output logic ok);
    logic a0, a1;
    a1 = 1'b0;
    startC; sendByte(dev(sub, 1'b0), a0);
    if (a0) sendByte(8'h3F, a1);
    stopC;
    ok = a0 & a1;
  endtask

  task automatic probe(input logic [7:0] devByte, output logic ack);
    startC; sendByte(devByte, ack); stopC;
  endtask

  task automatic readTx(input logic [2:0] sub, input logic [7:0] ptr,
                        output logic [7:0] data, output logic ok);
    logic a0, a1, a2;
    a1 = 1'b0; a2 = 1'b0; data = 8'hXX;
    startC; sendByte(dev(sub, 1'b0), a0);
    if (a0) begin
      sendByte(ptr, a1);
      startC; sendByte(dev(sub, 1'b1), a2);
      if (a2) getByte(1'b0, data);
    end
    stopC;
    ok = a0 & a1 & a2;
  endtask

  task automatic pulseReset;
    rstN = 1'b0; tick(4); rstN = 1'b1; tick(4);
  endtask

  initial begin
    logic ok, ack;
    logic [7:0] rd;
    logic [2:0] cur;
    tick(4); nvInitN = 1'b1; tick(4); rstN = 1'b1; tick(4);

    // reset state
    chk("R4 reset cfgCtrl", cfgCtrl, 8'hCD);
    chk("R5 reset cfgFreq", {4'h0, cfgFreq}, 8'h00);
    readTx(3'd0, 8'h02, rd, ok);
    chk("R3 read ack", {7'd0, ok}, 8'h01);
    chk("R4 read 02h", rd, 8'hCD);
    readTx(3'd0, 8'h08, rd, ok); chk("R5 read 08h", rd, 8'hF0);
    readTx(3'd0, 8'h0D, rd, ok); chk("R6 read 0Dh", rd, 8'hF0);
    readTx(3'd0, 8'h30, rd, ok); chk("R7 read undefined", rd, 8'hFF);

    // address mismatch
    probe(dev(3'd1, 1'b0), ack); chk("R1 foreign address nack", {7'd0, ack}, 8'h00);
    probe(dev(3'd0, 1'b1), ack); chk("R1 read address ack", {7'd0, ack}, 8'h01);

    // write with automatic backup
    writeTx(3'd0, 8'h08, 8'hFA, ok);
    chk("R2 write acks", {7'd0, ok}, 8'h01);
    chk("R5 cfgFreq after write", {4'h0, cfgFreq}, 8'h0A);
    probe(dev(3'd0, 1'b0), ack); chk("R11 nack while busy", {7'd0, ack}, 8'h00);
    tick(BUSY_CYC + 20);
    probe(dev(3'd0, 1'b0), ack); chk("R11 ack after busy", {7'd0, ack}, 8'h01);
    pulseReset;
    chk("R8 freq survives reset", {4'h0, cfgFreq}, 8'h0A);

    writeTx(3'd0, 8'h02, 8'h5A, ok);
    chk("R2 ctrl write acks", {7'd0, ok}, 8'h01);
    chk("R4 cfgCtrl after write", cfgCtrl, 8'h5A);
    tick(BUSY_CYC + 20);
    readTx(3'd0, 8'h02, rd, ok); chk("R4 read back 02h", rd, 8'h5A);

    // undefined register write
    writeTx(3'd0, 8'h40, 8'h00, ok);
    chk("R7 undefined write acks", {7'd0, ok}, 8'h01);
    probe(dev(3'd0, 1'b0), ack); chk("R7 no busy after undefined", {7'd0, ack}, 8'h01);
    chk("R7 ctrl unchanged", cfgCtrl, 8'h5A);
    readTx(3'd0, 8'h40, rd, ok); chk("R7 undefined reads FFh", rd, 8'hFF);

    // select explicit store; address register always commits
    writeTx(3'd0, 8'h0D, 8'h08, ok);
    probe(dev(3'd0, 1'b0), ack); chk("R10 addr write starts busy", {7'd0, ack}, 8'h00);
    tick(BUSY_CYC + 20);

    // sweep of frequency codes with WC=1: no busy, readback {F,code}
    for (int c = 0; c < 16; c++) begin
      writeTx(3'd0, 8'h08, 8'(c), ok);
      chk("R9 sweep write ack", {7'd0, ok}, 8'h01);
      chk("R5 sweep cfgFreq", {4'h0, cfgFreq}, 8'(c));
      readTx(3'd0, 8'h08, rd, ok);
      chk("R9 sweep read needs no wait", {7'd0, ok}, 8'h01);
      chk("R5 sweep readback", rd, {4'hF, 4'(c)});
    end
    pulseReset;
    chk("R9 uncommitted freq lost", {4'h0, cfgFreq}, 8'h0A);
    readTx(3'd0, 8'h0D, rd, ok); chk("R6 wc restored", rd, 8'hF8);

    writeTx(3'd0, 8'h08, 8'h03, ok);
    storeTx(3'd0, ok); chk("R9 store acks", {7'd0, ok}, 8'h01);
    probe(dev(3'd0, 1'b0), ack); chk("R9 store starts busy", {7'd0, ack}, 8'h00);
    tick(BUSY_CYC + 20);
    pulseReset;
    chk("R9 stored freq kept", {4'h0, cfgFreq}, 8'h03);

    // sweep of device addresses with WC=1
    cur = 3'd0;
    for (int a = 0; a < 8; a++) begin
      writeTx(cur, 8'h0D, {5'b00001, 3'(a)}, ok);
      chk("R10 addr write ack", {7'd0, ok}, 8'h01);
      tick(BUSY_CYC + 20);
      if (3'(a) != cur) begin
        probe(dev(cur, 1'b0), ack); chk("R1 old address ignored", {7'd0, ack}, 8'h00);
      end
      readTx(3'(a), 8'h0D, rd, ok);
      chk("R1 new address ack", {7'd0, ok}, 8'h01);
      chk("R6 addr readback", rd, {5'b11111, 3'(a)});
      cur = 3'(a);
    end
    pulseReset;
    readTx(3'd7, 8'h08, rd, ok);
    chk("R10 address kept over reset", {7'd0, ok}, 8'h01);
    chk("R12 freq via new address", rd, 8'hF3);

    // factory initialisation
    nvInitN = 1'b0; rstN = 1'b0; tick(4); nvInitN = 1'b1; tick(4); rstN = 1'b1; tick(4);
    chk("R12 factory ctrl", cfgCtrl, 8'hCD);
    chk("R12 factory freq", {4'h0, cfgFreq}, 8'h00);
    readTx(3'd0, 8'h0D, rd, ok); chk("R12 factory addr reg", rd, 8'hF0);

    chk("R13 pull-down changes with SCL high", 8'(pdHighChanges), 8'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checkCount, errorCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      errorCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checkCount, errorCount);
      $finish;
    end
  end
endmodule